// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block gathers interrupt requests from one non-maskable input, eight active-low external request pins and a parameterised group of internal peripheral request lines. It turns them into one request towards the processor, which carries the winning priority level and a fixed vector number. Each maskable source has a 4-bit programmable priority. Level 0 switches a source off. Each external pin can be programmed to sense either a low level or a falling edge. An edge is held in a per-pin flag until the processor accepts the interrupt.

The processor compares nothing itself. It drives its current mask level into the block, and the block raises a request only when the best pending level is strictly above that mask. A non-maskable request always gets through. Once raised, the request, level and vector stay frozen until the processor acknowledges them. At that point the level on the output is the value the processor copies into its mask bits. Software programs priorities and sensing through a small synchronous write port with a combinational read port.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `req_o` is low and every register reads 0x0000 while all pins are held high.
- R2: Priority register k (address k, with k from 0 to 3) holds source 4k+f in bits [4f+3:4f]. Address 4 holds the sense bits in bits [7:0], one bit per pin. Bits with no source or pin behind them read as 0.
- R3: With a pin's sense bit at 0, the pin is pending while it is low. Acceptance does not clear it, so the pin is requested again while it stays low.
- R4: With a pin's sense bit at 1, a high-to-low transition sets that pin's flag. Acceptance of that pin clears the flag. A new falling edge in the same cycle as the acceptance leaves the flag set.
- R5: Address 5 bits [7:0] read the per-pin request flags.
- R6: A source with priority 0 never produces a request.
- R7: A maskable source is requested only when its priority is strictly greater than `mask_i`.
- R8: The highest pending priority wins. Among equal priorities, the lower source index wins, where pins are indices 0 to 7 and peripheral line j is index 8+j.
- R9: A rising edge on `nmi_i` is latched and requested with level 16 and vector 11, whatever the mask and the other sources. Acceptance clears it.
- R10: Pin i gives vector 64+i, and peripheral line j gives vector 72+j.
- R11: While `req_o` is high and `ack_i` is low, `req_o`, `lvl_o` and `vec_o` hold. The cycle after `ack_i` is seen, `req_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 16 | Register write data |
| rdata_o | output | 16 | Register read data (combinational) |
| nmi_i | input | 1 | Non-maskable request, rising edge |
| irq_ni | input | 8 | External request pins, active low |
| periph_req_i | input | 6 | Internal peripheral request lines, active high |
| mask_i | input | 4 | Current processor mask level |
| ack_i | input | 1 | Processor accepts the presented request |
| req_o | output | 1 | Interrupt request to the processor |
| lvl_o | output | 5 | Level of the presented request (16 for non-maskable) |
| vec_o | output | 8 | Vector number of the presented request |

## Verification
The edge flag of a pin can be cleared by acceptance in the same cycle as a new falling edge sets it. The bench provokes this on purpose. It holds an edge-sensed request unacknowledged, raises the pin, and then drives the pin low on the same clock as `ack_i`. The flag register must still show the pin, and a fresh request with the same vector must follow. Randomised rounds also let arbitration meet the hold rule: inputs settle while the mask blocks everything, the mask then opens, and the frozen result is compared with a model of R7, R8 and R10.

// File: rtl/pic_pkg.sv
package pic_pkg;

   localparam int unsigned REG_W = 16;

   typedef enum logic {
      SENSE_LEVEL = 1'b0,
      SENSE_FALL  = 1'b1
   } sense_e;

endpackage

// File: rtl/pic_pin_sense.sv
module pic_pin_sense
   import pic_pkg::*;
(
   input  logic clk_i,
   input  logic rst_ni,
   input  logic pin_ni,
   input  logic sense_i,
   input  logic clr_i,
   output logic flag_o
);

   logic pin_q;
   logic edge_q;
   logic fall;

   assign fall = pin_q & ~pin_ni;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pin_q  <= 1'b1;
         edge_q <= 1'b0;
      end else begin
         pin_q <= pin_ni;
         if (sense_i == SENSE_FALL) begin
            if (fall)
               edge_q <= 1'b1;
            else if (clr_i)
               edge_q <= 1'b0;
         end else begin
            edge_q <= 1'b0;
         end
      end
   end

   assign flag_o = (sense_i == SENSE_FALL) ? edge_q : ~pin_q;

endmodule

// File: rtl/pic_regfile.sv
module pic_regfile
   import pic_pkg::*;
#(
   parameter int unsigned N_SRC  = 14,
   parameter int unsigned N_PIN  = 8,
   parameter int unsigned LVL_W  = 4,
   parameter int unsigned ADDR_W = 3
) (
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic                   wr_en_i,
   input  logic [ADDR_W-1:0]      addr_i,
   input  logic [REG_W-1:0]       wdata_i,
   input  logic [N_PIN-1:0]       flags_i,
   output logic [REG_W-1:0]       rdata_o,
   output logic [N_SRC*LVL_W-1:0] prio_o,
   output logic [N_PIN-1:0]       sense_o
);

   localparam int unsigned FPR        = REG_W / LVL_W;
   localparam int unsigned N_PRIO_REG = (N_SRC + FPR - 1) / FPR;
   localparam int unsigned SENSE_ADDR = N_PRIO_REG;
   localparam int unsigned FLAG_ADDR  = N_PRIO_REG + 1;

   logic [N_PIN-1:0] sense_q;

   for (genvar s = 0; s < N_SRC; s++) begin : g_field
      localparam int unsigned REG_IDX = s / FPR;
      localparam int unsigned LSB     = (s % FPR) * LVL_W;
      logic [LVL_W-1:0] field_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)
            field_q <= '0;
         else if (wr_en_i && int'(addr_i) == REG_IDX)
            field_q <= wdata_i[LSB +: LVL_W];
      end
      assign prio_o[s*LVL_W +: LVL_W] = field_q;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
         sense_q <= '0;
      else if (wr_en_i && int'(addr_i) == SENSE_ADDR)
         sense_q <= wdata_i[N_PIN-1:0];
   end

   assign sense_o = sense_q;

   always_comb begin
      rdata_o = '0;
      if (int'(addr_i) < N_PRIO_REG) begin
         for (int s = 0; s < N_SRC; s++) begin
            if (int'(addr_i) == s / FPR)
               rdata_o[(s % FPR) * LVL_W +: LVL_W] = prio_o[s*LVL_W +: LVL_W];
         end
      end else if (int'(addr_i) == SENSE_ADDR) begin
         rdata_o[N_PIN-1:0] = sense_q;
      end else if (int'(addr_i) == FLAG_ADDR) begin
         rdata_o[N_PIN-1:0] = flags_i;
      end
   end

endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter #(
   parameter int unsigned N_SRC = 14,
   parameter int unsigned LVL_W = 4,
   parameter int unsigned SRC_W = 4
) (
   input  logic [N_SRC-1:0]       pend_i,
   input  logic [N_SRC*LVL_W-1:0] prio_i,
   output logic                   valid_o,
   output logic [LVL_W-1:0]       lvl_o,
   output logic [SRC_W-1:0]       idx_o
);

   always_comb begin
      valid_o = 1'b0;
      lvl_o   = '0;
      idx_o   = '0;
      for (int s = 0; s < N_SRC; s++) begin
         if (pend_i[s] && prio_i[s*LVL_W +: LVL_W] > lvl_o) begin
            valid_o = 1'b1;
            lvl_o   = prio_i[s*LVL_W +: LVL_W];
            idx_o   = SRC_W'(s);
         end
      end
   end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
   import pic_pkg::*;
#(
   parameter int unsigned N_PIN           = 8,
   parameter int unsigned N_PERIPH        = 6,
   parameter int unsigned LVL_W           = 4,
   parameter int unsigned VEC_W           = 8,
   parameter int unsigned ADDR_W          = 3,
   parameter int unsigned NMI_VEC         = 11,
   parameter int unsigned PIN_VEC_BASE    = 64,
   parameter int unsigned PERIPH_VEC_BASE = 72
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                wr_en_i,
   input  logic [ADDR_W-1:0]   addr_i,
   input  logic [REG_W-1:0]    wdata_i,
   output logic [REG_W-1:0]    rdata_o,
   input  logic                nmi_i,
   input  logic [N_PIN-1:0]    irq_ni,
   input  logic [N_PERIPH-1:0] periph_req_i,
   input  logic [LVL_W-1:0]    mask_i,
   input  logic                ack_i,
   output logic                req_o,
   output logic [LVL_W:0]      lvl_o,
   output logic [VEC_W-1:0]    vec_o
);

   localparam int unsigned N_SRC      = N_PIN + N_PERIPH;
   localparam int unsigned SRC_W      = $clog2(N_SRC);
   localparam int unsigned FPR        = REG_W / LVL_W;
   localparam int unsigned N_PRIO_REG = (N_SRC + FPR - 1) / FPR;
   localparam int unsigned TOP_LVL    = 1 << LVL_W;

   if (N_PIN < 1 || N_PIN > REG_W) begin : g_bad_pins
      $error("N_PIN must lie between 1 and the register width");
   end
   if (REG_W % LVL_W != 0) begin : g_bad_lvl
      $error("LVL_W must divide the register width");
   end
   if (N_PRIO_REG + 2 > (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too narrow for the register map");
   end
   if (PERIPH_VEC_BASE + N_PERIPH > (1 << VEC_W) ||
       PIN_VEC_BASE + N_PIN > (1 << VEC_W) || NMI_VEC >= (1 << VEC_W)) begin : g_bad_vec
      $error("vector numbers do not fit VEC_W");
   end

   logic [N_SRC*LVL_W-1:0] prio;
   logic [N_PIN-1:0]       sense;
   logic [N_PIN-1:0]       pin_flag;
   logic [N_PIN-1:0]       pin_clr;
   logic [N_SRC-1:0]       pend;

   logic                   best_valid;
   logic [LVL_W-1:0]       best_lvl;
   logic [SRC_W-1:0]       best_idx;
   logic [VEC_W-1:0]       best_vec;

   logic                   nmi_q;
   logic                   nmi_pend;
   logic                   take;

   logic                   req_q;
   logic [LVL_W:0]         lvl_q;
   logic [VEC_W-1:0]       vec_q;
   logic [SRC_W-1:0]       src_q;
   logic                   nmi_sel_q;
   logic                   accept;

   pic_regfile #(
      .N_SRC (N_SRC),
      .N_PIN (N_PIN),
      .LVL_W (LVL_W),
      .ADDR_W(ADDR_W)
   ) u_regs (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_en_i(wr_en_i),
      .addr_i (addr_i),
      .wdata_i(wdata_i),
      .flags_i(pin_flag),
      .rdata_o(rdata_o),
      .prio_o (prio),
      .sense_o(sense)
   );

   assign accept = req_q & ack_i;

   for (genvar i = 0; i < N_PIN; i++) begin : g_pin
      assign pin_clr[i] = accept & ~nmi_sel_q & (int'(src_q) == i);
      pic_pin_sense u_sense (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .pin_ni (irq_ni[i]),
         .sense_i(sense[i]),
         .clr_i  (pin_clr[i]),
         .flag_o (pin_flag[i])
      );
   end

   for (genvar s = 0; s < N_SRC; s++) begin : g_pend
      logic raw;
      if (s < N_PIN) begin : g_from_pin
         assign raw = pin_flag[s];
      end else begin : g_from_periph
         assign raw = periph_req_i[s - N_PIN];
      end
      assign pend[s] = raw & (prio[s*LVL_W +: LVL_W] != '0);
   end

   pic_arbiter #(
      .N_SRC(N_SRC),
      .LVL_W(LVL_W),
      .SRC_W(SRC_W)
   ) u_arb (
      .pend_i (pend),
      .prio_i (prio),
      .valid_o(best_valid),
      .lvl_o  (best_lvl),
      .idx_o  (best_idx)
   );

   always_comb begin
      if (int'(best_idx) < N_PIN)
         best_vec = VEC_W'(PIN_VEC_BASE + int'(best_idx));
      else
         best_vec = VEC_W'(PERIPH_VEC_BASE + int'(best_idx) - N_PIN);
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         nmi_q    <= 1'b0;
         nmi_pend <= 1'b0;
      end else begin
         nmi_q <= nmi_i;
         if (nmi_i & ~nmi_q)
            nmi_pend <= 1'b1;
         else if (accept & nmi_sel_q)
            nmi_pend <= 1'b0;
      end
   end

   assign take = nmi_pend | (best_valid & (best_lvl > mask_i));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         req_q     <= 1'b0;
         lvl_q     <= '0;
         vec_q     <= '0;
         src_q     <= '0;
         nmi_sel_q <= 1'b0;
      end else if (req_q) begin
         if (ack_i)
            req_q <= 1'b0;
      end else if (take) begin
         req_q     <= 1'b1;
         nmi_sel_q <= nmi_pend;
         src_q     <= best_idx;
         if (nmi_pend) begin
            lvl_q <= (LVL_W+1)'(TOP_LVL);
            vec_q <= VEC_W'(NMI_VEC);
         end else begin
            lvl_q <= {1'b0, best_lvl};
            vec_q <= best_vec;
         end
      end
   end

   assign req_o = req_q;
   assign lvl_o = lvl_q;
   assign vec_o = vec_q;

endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
   parameter int unsigned LVL_W   = 4,
   parameter int unsigned VEC_W   = 8,
   parameter int unsigned NMI_VEC = 11
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic [LVL_W-1:0] mask_i,
   input logic             ack_i,
   input logic             req_o,
   input logic [LVL_W:0]   lvl_o,
   input logic [VEC_W-1:0] vec_o
);

   localparam int unsigned TOP_LVL = 1 << LVL_W;

   AST_HOLD_UNTIL_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_o && !ack_i |=> req_o && $stable(lvl_o) && $stable(vec_o)); // R11

   AST_DROP_AFTER_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_o && ack_i |=> !req_o); // R11

   AST_ABOVE_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(req_o) && vec_o != VEC_W'(NMI_VEC) |-> lvl_o > (LVL_W+1)'($past(mask_i))); // R7

   AST_NMI_TOP_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_o && vec_o == VEC_W'(NMI_VEC) |-> lvl_o == (LVL_W+1)'(TOP_LVL)); // R9

   AST_NO_ZERO_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_o |-> lvl_o != '0); // R6

endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(
   .LVL_W  (LVL_W),
   .VEC_W  (VEC_W),
   .NMI_VEC(NMI_VEC)
) u_chk (
   .clk_i (clk_i),
   .rst_ni(rst_ni),
   .mask_i(mask_i),
   .ack_i (ack_i),
   .req_o (req_o),
   .lvl_o (lvl_o),
   .vec_o (vec_o)
);

// File: tb/tb_prio_irq_ctrl.sv
`timescale 1ns/1ps
module tb_prio_irq_ctrl;

   logic        clk_i = 1'b0;
   logic        rst_ni = 1'b0;
   logic        wr_en_i = 1'b0;
   logic [2:0]  addr_i = '0;
   logic [15:0] wdata_i = '0;
   logic [15:0] rdata_o;
   logic        nmi_i = 1'b0;
   logic [7:0]  irq_ni = 8'hFF;
   logic [5:0]  periph_req_i = '0;
   logic [3:0]  mask_i = '0;
   logic        ack_i = 1'b0;
   logic        req_o;
   logic [4:0]  lvl_o;
   logic [7:0]  vec_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic [3:0] prio_m [14];

   always #2 clk_i = ~clk_i;

   prio_irq_ctrl dut (
      .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
      .wdata_i(wdata_i), .rdata_o(rdata_o), .nmi_i(nmi_i), .irq_ni(irq_ni),
      .periph_req_i(periph_req_i), .mask_i(mask_i), .ack_i(ack_i),
      .req_o(req_o), .lvl_o(lvl_o), .vec_o(vec_o)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic cycles(input int n);
      repeat (n) @(negedge clk_i);
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk_i);
      wr_en_i = 1'b1; addr_i = a; wdata_i = d;
      @(negedge clk_i);
      wr_en_i = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [15:0] d);
      @(negedge clk_i);
      addr_i = a;
      #1 d = rdata_o;
   endtask

   task automatic push_prio();
      for (int r = 0; r < 4; r++) begin
         logic [15:0] w;
         w = '0;
         for (int f = 0; f < 4; f++)
            if (r*4 + f < 14) w[f*4 +: 4] = prio_m[r*4 + f];
         wr(3'(r), w);
      end
   endtask

   task automatic pulse_ack();
      @(negedge clk_i);
      ack_i = 1'b1;
      @(negedge clk_i);
      ack_i = 1'b0;
   endtask

   function automatic void model(input logic [7:0] pins_n, input logic [5:0] per,
                                 input logic [3:0] msk, output logic v,
                                 output logic [4:0] l, output logic [7:0] vec);
      logic [3:0] best;
      int idx;
      best = 0; idx = -1;
      for (int s = 0; s < 14; s++) begin
         logic p;
         p = (s < 8) ? ~pins_n[s] : per[s-8];
         if (p && prio_m[s] != 0 && prio_m[s] > best) begin
            best = prio_m[s]; idx = s;
         end
      end
      v = (idx >= 0) && (best > msk);
      l = {1'b0, best};
      vec = (idx < 8) ? 8'(64 + idx) : 8'(72 + idx - 8);
   endfunction

   initial begin
      repeat (100000) @(posedge clk_i);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [15:0] d;
      logic ev;
      logic [4:0] el;
      logic [7:0] evec;
      void'($urandom(32'h1CE5));
      for (int s = 0; s < 14; s++) prio_m[s] = '0;
      cycles(4);
      rst_ni = 1'b1;
      cycles(2);

      // R1 reset state
      check("R1 req after reset", req_o, 0);
      for (int a = 0; a < 6; a++) begin
         rd(3'(a), d);
         check("R1 register reset value", d, 0);
      end

      // R2 layout and reserved bits
      wr(3'd3, 16'hFFFF); rd(3'd3, d);
      check("R2 reg3 only two fields", d, 16'h00FF);
      wr(3'd4, 16'hFFFF); rd(3'd4, d);
      check("R2 sense upper bits read 0", d, 16'h00FF);
      wr(3'd0, 16'h1234); rd(3'd0, d);
      check("R2 reg0 readback", d, 16'h1234);
      wr(3'd0, 0); wr(3'd3, 0); wr(3'd4, 0);

      // R6 priority 0 disables, R5 flag still visible
      irq_ni[0] = 1'b0; cycles(4);
      check("R6 no request at priority 0", req_o, 0);
      rd(3'd5, d);
      check("R5 level flag of pin 0", d, 16'h0001);

      // R3 / R10 level sensing
      wr(3'd0, 16'h0003); cycles(3);
      check("R3 level request raised", req_o, 1);
      check("R10 pin 0 vector", vec_o, 64);
      check("R3 level value", lvl_o, 3);
      pulse_ack(); cycles(2);
      check("R3 level pin re-requested while low", req_o, 1);
      irq_ni[0] = 1'b1; cycles(2);
      pulse_ack(); cycles(3);
      check("R3 no request after pin released", req_o, 0);

      // R7 masking
      mask_i = 4'd3; irq_ni[0] = 1'b0; cycles(4);
      check("R7 equal to mask blocked", req_o, 0);
      mask_i = 4'd2; cycles(2);
      check("R7 above mask accepted", req_o, 1);
      irq_ni[0] = 1'b1; cycles(2); pulse_ack(); mask_i = 4'd0;
      wr(3'd0, 16'h0000); cycles(2);

      // R4 edge sensing
      wr(3'd4, 16'h0004); wr(3'd0, 16'h0500);
      irq_ni[2] = 1'b0; cycles(1); irq_ni[2] = 1'b1; cycles(3);
      rd(3'd5, d);
      check("R5 edge flag of pin 2", d, 16'h0004);
      check("R4 edge request raised", req_o, 1);
      check("R10 pin 2 vector", vec_o, 66);
      pulse_ack(); cycles(2);
      rd(3'd5, d);
      check("R4 flag cleared on acceptance", d, 16'h0000);
      check("R4 no request after acceptance", req_o, 0);

      // R4 new edge in the same cycle as acceptance
      irq_ni[2] = 1'b0; cycles(3);
      irq_ni[2] = 1'b1; cycles(2);
      check("R4 held edge request", req_o, 1);
      @(negedge clk_i); irq_ni[2] = 1'b0; ack_i = 1'b1;
      @(negedge clk_i); ack_i = 1'b0;
      cycles(2);
      rd(3'd5, d);
      check("R4 flag kept by colliding edge", d, 16'h0004);
      check("R4 request reissued", req_o, 1);
      check("R4 reissued vector", vec_o, 66);
      pulse_ack(); cycles(2);
      check("R4 cleared after second acceptance", req_o, 0);
      irq_ni[2] = 1'b1; wr(3'd4, 0); wr(3'd0, 0);

      // R8 ties: periph 0 (src 8) and periph 3 (src 11) at level 7
      wr(3'd2, 16'h7007); periph_req_i = 6'b001001; cycles(3);
      check("R8 tie lower index wins", vec_o, 72);
      periph_req_i = 6'b001000; pulse_ack(); cycles(2);
      check("R10 peripheral 3 vector", vec_o, 75);
      periph_req_i = '0; pulse_ack(); cycles(2);

      // R9 non-maskable
      periph_req_i = 6'b000001; mask_i = 4'd15; cycles(3);
      check("R9 maskable blocked at mask 15", req_o, 0);
      nmi_i = 1'b1; cycles(3);
      check("R9 nmi request", req_o, 1);
      check("R9 nmi vector", vec_o, 11);
      check("R9 nmi level", lvl_o, 16);
      pulse_ack(); cycles(3);
      check("R9 nmi cleared, input still high", req_o, 0);
      nmi_i = 1'b0; periph_req_i = '0; wr(3'd2, 0); cycles(2);

      // R7 R8 R10 R11 randomised rounds
      for (int it = 0; it < 40; it++) begin
         logic [3:0] m;
         mask_i = 4'd15;
         for (int s = 0; s < 14; s++) prio_m[s] = 4'($urandom % 16);
         push_prio();
         irq_ni = 8'($urandom);
         periph_req_i = 6'($urandom);
         m = 4'($urandom % 16);
         cycles(2);
         check("R7 closed mask", req_o, 0);
         mask_i = m;
         cycles(3);
         model(irq_ni, periph_req_i, m, ev, el, evec);
         check("R7 random request", req_o, ev);
         if (ev) begin
            check("R8 random level", lvl_o, el);
            check("R8 random vector", vec_o, evec);
            cycles(2);
            check("R11 vector held", vec_o, evec);
         end
         @(negedge clk_i); mask_i = 4'd15; ack_i = req_o;
         @(negedge clk_i); ack_i = 1'b0;
         cycles(1);
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule